// File: doc/BRIEF.md
# Set-Associative Instruction Cache Controller

This block is a read-only instruction cache placed between an instruction fetch unit and a word-wide memory read port. Every fetch carries a byte address. The block takes the address apart into three fields: a word offset inside the line, a set index and a tag. It then compares the tag with every way of the indexed set. On a hit the stored word is returned after a fixed hit delay, and memory is not touched. On a miss the block picks a victim way and refills the whole line. The refill starts with the requested word and wraps around inside the line. After the refill and a fixed miss delay, the block returns the requested word.

Each way carries a valid bit, a tag and a small saturating age counter. These drive replacement. Lines can be invalidated by address. While the cache is disabled, fetches are sent straight to memory and leave the cache untouched. An invalidate issued while the cache is disabled wipes the whole indexed set. A memory error during a refill aborts the refill and returns an error with a zero word.

Top module: `icache_ctrl`

## Requirements
- R1: The byte address is split into fields as follows: bits [3:2] are the word offset, bits [5:4] are the set index and bits [31:6] are the tag (default line of 4 words, 4 sets, 2 ways). A fetch that hits returns the word stored at its offset in the matching way.
- R2: A hit raises `resp_done` HIT_DELAY+2 cycles after the cycle in which the request was accepted. A hit issues no memory read.
- R3: A miss issues exactly LINE_WORDS memory reads, all word aligned and inside the line-aligned block. The reads start at the requested word and wrap modulo the line size. A read request holds its address until `mem_rd_ready`.
- R4: When memory never stalls, a miss raises `resp_done` LINE_WORDS+MISS_DELAY+2 cycles after acceptance. It returns the requested word, and the refilled line then hits.
- R5: The victim is chosen as follows. The lowest-numbered invalid way is taken first. If every way is valid, the way with the smallest age is taken, and the lowest index wins a tie. A filled or hit way takes the top age. A fill decrements every other non-zero age in the set. A hit decrements only the ages that are above the hit way's old age.
- R6: With `cache_en` low at acceptance, a fetch makes one memory read of the word-aligned address. It raises `resp_done` 2 cycles after acceptance and leaves every tag, valid bit and age unchanged.
- R7: An invalidate with `cache_en` high clears the valid bit and the age of the way whose tag matches. Other ways, and any address whose tag does not match, are left untouched.
- R8: An invalidate with `cache_en` low clears every way of the indexed set, whatever the tag.
- R9: A memory error during a refill ends the refill at once. `resp_done` then comes with `resp_err`=1 and `resp_data`=0, and the line stays invalid, so the next fetch to it misses.
- R10: `req_ready` is high only when the block is idle and no invalidate is pending. `resp_done` is a one-cycle pulse. No memory read is issued while the block is idle.
- R11: After reset, `req_ready`=1, `resp_done`=0, `mem_rd_valid`=0, and every way is invalid with age zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_en | input | 1 | Cache enable; sampled when a fetch or an invalidate is taken |
| req_valid | input | 1 | Fetch request |
| req_addr | input | ADDR_W | Fetch byte address |
| req_ready | output | 1 | Fetch can be accepted this cycle |
| inv_valid | input | 1 | Invalidate request; has priority over a fetch |
| inv_addr | input | ADDR_W | Invalidate byte address |
| inv_ready | output | 1 | Invalidate is taken this cycle |
| resp_done | output | 1 | One-cycle completion strobe |
| resp_data | output | 32 | Fetched word |
| resp_err | output | 1 | Memory error on this fetch |
| mem_rd_valid | output | 1 | Memory word read request |
| mem_rd_addr | output | ADDR_W | Word-aligned memory read address |
| mem_rd_ready | input | 1 | Memory returns data or an error this cycle |
| mem_rd_data | input | 32 | Memory read data |
| mem_rd_err | input | 1 | Memory access error |

## Verification
The assertions assume a few things about the environment. The memory side returns `mem_rd_data` and `mem_rd_err` in the same cycle as `mem_rd_ready`. Memory eventually answers. A request is presented only while `req_ready` is high, and an invalidate only while `inv_ready` is high. The bench meets these terms in three ways. Its memory model is combinational and always ready. It raises the error flag only on one chosen beat address. It drives each fetch or invalidate for a single cycle, and only after seeing the matching ready signal at a falling edge.

// File: rtl/icache_pkg.sv
// Package: types shared by the instruction cache controller.
package icache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL,
        ST_HOLD,
        ST_BYPASS,
        ST_RESP
    } ic_state_e;
endpackage

// File: rtl/icache_tag_store.sv
// Tag store: valid bit, tag and saturating age per way of every set.
// Assumes SETS and WAYS are powers of two, WAYS >= 2, and that at most
// one update command is active in any cycle (the controller guarantees it).
module icache_tag_store #(
    parameter int SETS       = 4,
    parameter int WAYS       = 2,
    parameter int TAG_W      = 26,
    parameter int AGE_LEVELS = 4,
    localparam int SET_W     = $clog2(SETS),
    localparam int WAY_W     = $clog2(WAYS),
    localparam int AGE_W     = $clog2(AGE_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SET_W-1:0]      lk_set,
    input  logic [TAG_W-1:0]      lk_tag,
    output logic [WAYS-1:0]       hit_vec,
    output logic [WAYS-1:0]       valid_vec,
    output logic [WAYS*AGE_W-1:0] age_flat,
    input  logic                  touch_en,
    input  logic [WAY_W-1:0]      touch_way,
    input  logic                  kill_en,
    input  logic [WAY_W-1:0]      kill_way,
    input  logic                  fill_en,
    input  logic [WAY_W-1:0]      fill_way,
    input  logic                  inv_match_en,
    input  logic                  inv_set_en
);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(AGE_LEVELS - 1);

    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic             valid_q [SETS][WAYS];
    logic [AGE_W-1:0] age_q   [SETS][WAYS];

    // Per-way compare and read-out of the looked-up set.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w]                 = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
        assign valid_vec[w]               = valid_q[lk_set][w];
        assign age_flat[w*AGE_W +: AGE_W] = age_q[lk_set][w];
    end

    // Apply hit, kill, fill and invalidate updates to the looked-up set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]   <= '0;
                    valid_q[s][w] <= 1'b0;
                    age_q[s][w]   <= '0;
                end
            end
        end else begin
            if (touch_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == touch_way)
                        age_q[lk_set][w] <= AGE_MAX;
                    else if (age_q[lk_set][w] > age_q[lk_set][touch_way])
                        age_q[lk_set][w] <= age_q[lk_set][w] - 1'b1;
                end
            end
            if (kill_en)
                valid_q[lk_set][kill_way] <= 1'b0;
            if (fill_en) begin
                tag_q[lk_set][fill_way]   <= lk_tag;
                valid_q[lk_set][fill_way] <= 1'b1;
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == fill_way)
                        age_q[lk_set][w] <= AGE_MAX;
                    else if (age_q[lk_set][w] != '0)
                        age_q[lk_set][w] <= age_q[lk_set][w] - 1'b1;
                end
            end
            if (inv_match_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (hit_vec[w]) begin
                        valid_q[lk_set][w] <= 1'b0;
                        age_q[lk_set][w]   <= '0;
                    end
                end
            end
            if (inv_set_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[lk_set][w] <= 1'b0;
                    age_q[lk_set][w]   <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/icache_victim.sv
// Victim selection: lowest invalid way, otherwise the lowest-index way
// with the smallest age. Purely combinational.
module icache_victim #(
    parameter int WAYS  = 2,
    parameter int AGE_W = 2,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]       valid_vec,
    input  logic [WAYS*AGE_W-1:0] age_flat,
    output logic [WAY_W-1:0]      victim
);
    // Scan for the first invalid way, then for the minimum age.
    always_comb begin
        logic             found;
        logic [AGE_W-1:0] best;
        found  = 1'b0;
        best   = '1;
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!valid_vec[w] && !found) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_flat[w*AGE_W +: AGE_W] < best) begin
                    best   = age_flat[w*AGE_W +: AGE_W];
                    victim = WAY_W'(w);
                end
            end
        end
    end
endmodule

// File: rtl/icache_data_store.sv
// Line data: one 32-bit word per (set, way, offset); one write port and
// one combinational read port.
module icache_data_store #(
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [31:0]      rdata
);
    logic [31:0] mem_q [DEPTH];

    // Store one refill word.
    always_ff @(posedge clk) begin
        if (we)
            mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/icache_ctrl.sv
// Instruction cache controller top. Accepts one fetch at a time, looks the
// line up, refills it critical-word-first on a miss, bypasses when disabled,
// and services invalidates while idle. Assumes HIT_DELAY, MISS_DELAY >= 1,
// LINE_WORDS >= 2, and the memory answers data/error together with ready.
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 4,
    parameter int WAYS       = 2,
    parameter int LINE_WORDS = 4,
    parameter int AGE_LEVELS = 4,
    parameter int HIT_DELAY  = 1,
    parameter int MISS_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    output logic              inv_ready,
    output logic              resp_done,
    output logic [31:0]       resp_data,
    output logic              resp_err,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ready,
    input  logic [31:0]       mem_rd_data,
    input  logic              mem_rd_err
);
    localparam int OFF_W   = $clog2(LINE_WORDS);
    localparam int SET_W   = $clog2(SETS);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int AGE_W   = $clog2(AGE_LEVELS);
    localparam int TAG_W   = ADDR_W - 2 - OFF_W - SET_W;
    localparam int DLY_MAX = (HIT_DELAY > MISS_DELAY) ? HIT_DELAY : MISS_DELAY;
    localparam int CNT_W   = $clog2(DLY_MAX + 1);
    localparam int DEPTH   = SETS * WAYS * LINE_WORDS;

    ic_state_e          state_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [WAY_W-1:0]   way_q;
    logic [OFF_W-1:0]   beat_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [31:0]        data_q;
    logic               err_q;

    logic [OFF_W-1:0]   req_off, fill_word;
    logic [SET_W-1:0]   req_set, inv_set, lk_set;
    logic [TAG_W-1:0]   req_tag, inv_tag, lk_tag;
    logic [WAYS-1:0]    hit_vec, valid_vec;
    logic [WAYS*AGE_W-1:0] age_flat;
    logic [WAY_W-1:0]   hit_way, victim;
    logic               hit_any, beat_last, beat_ok;
    logic [31:0]        rd_word;
    logic               unused_bits;

    assign req_off   = addr_q[2 +: OFF_W];
    assign req_set   = addr_q[2 + OFF_W +: SET_W];
    assign req_tag   = addr_q[ADDR_W-1 -: TAG_W];
    assign inv_set   = inv_addr[2 + OFF_W +: SET_W];
    assign inv_tag   = inv_addr[ADDR_W-1 -: TAG_W];
    assign lk_set    = (state_q == ST_IDLE) ? inv_set : req_set;
    assign lk_tag    = (state_q == ST_IDLE) ? inv_tag : req_tag;
    assign fill_word = req_off + beat_q;
    assign beat_last = (beat_q == OFF_W'(LINE_WORDS - 1));
    assign beat_ok   = (state_q == ST_FILL) && mem_rd_ready && !mem_rd_err;
    assign hit_any   = |hit_vec;
    assign unused_bits = ^{req_addr[1:0], inv_addr[1 + OFF_W:0], addr_q[1:0]};

    assign req_ready    = (state_q == ST_IDLE) && !inv_valid;
    assign inv_ready    = (state_q == ST_IDLE);
    assign resp_done    = (state_q == ST_RESP);
    assign resp_data    = data_q;
    assign resp_err     = err_q;
    assign mem_rd_valid = (state_q == ST_FILL) || (state_q == ST_BYPASS);
    assign mem_rd_addr  = (state_q == ST_FILL)
                        ? {addr_q[ADDR_W-1:2+OFF_W], fill_word, 2'b00}
                        : {addr_q[ADDR_W-1:2], 2'b00};

    // Encode the matching way of the current lookup.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
    end

    icache_tag_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .AGE_LEVELS(AGE_LEVELS)
    ) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_set(lk_set), .lk_tag(lk_tag),
        .hit_vec(hit_vec), .valid_vec(valid_vec), .age_flat(age_flat),
        .touch_en((state_q == ST_LOOKUP) && hit_any), .touch_way(hit_way),
        .kill_en((state_q == ST_LOOKUP) && !hit_any), .kill_way(victim),
        .fill_en(beat_ok && beat_last), .fill_way(way_q),
        .inv_match_en((state_q == ST_IDLE) && inv_valid && cache_en),
        .inv_set_en((state_q == ST_IDLE) && inv_valid && !cache_en)
    );

    icache_victim #(.WAYS(WAYS), .AGE_W(AGE_W)) u_victim (
        .valid_vec(valid_vec), .age_flat(age_flat), .victim(victim)
    );

    icache_data_store #(.DEPTH(DEPTH)) u_data (
        .clk(clk), .we(beat_ok),
        .waddr({req_set, way_q, fill_word}), .wdata(mem_rd_data),
        .raddr({req_set, hit_way, req_off}), .rdata(rd_word)
    );

    // Fetch sequencing: accept, look up, refill or bypass, delay, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            way_q   <= '0;
            beat_q  <= '0;
            cnt_q   <= '0;
            data_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (!inv_valid && req_valid) begin
                    addr_q  <= req_addr;
                    state_q <= cache_en ? ST_LOOKUP : ST_BYPASS;
                end
                ST_LOOKUP: if (hit_any) begin
                    data_q  <= rd_word;
                    err_q   <= 1'b0;
                    cnt_q   <= CNT_W'(HIT_DELAY - 1);
                    state_q <= ST_HOLD;
                end else begin
                    way_q   <= victim;
                    beat_q  <= '0;
                    state_q <= ST_FILL;
                end
                ST_FILL: if (mem_rd_ready) begin
                    if (mem_rd_err) begin
                        data_q  <= '0;
                        err_q   <= 1'b1;
                        state_q <= ST_RESP;
                    end else begin
                        if (beat_q == '0) data_q <= mem_rd_data;
                        beat_q <= beat_q + 1'b1;
                        if (beat_last) begin
                            err_q   <= 1'b0;
                            cnt_q   <= CNT_W'(MISS_DELAY - 1);
                            state_q <= ST_HOLD;
                        end
                    end
                end
                ST_HOLD: if (cnt_q == '0) state_q <= ST_RESP;
                         else cnt_q <= cnt_q - 1'b1;
                ST_BYPASS: if (mem_rd_ready) begin
                    data_q  <= mem_rd_err ? 32'h0 : mem_rd_data;
                    err_q   <= mem_rd_err;
                    state_q <= ST_RESP;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/icache_ctrl_sva.sv
// Checker for icache_ctrl: port-level protocol properties, bound below.
module icache_ctrl_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              inv_valid,
    input logic              resp_done,
    input logic [31:0]       resp_data,
    input logic              resp_err,
    input logic              mem_rd_valid,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_ready
);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done);

    p_busy_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |-> !req_ready);

    p_inv_blocks_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> !req_ready);

    p_idle_no_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_valid);

    p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    p_word_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (mem_rd_addr[1:0] == 2'b00));

    p_err_zero_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_done && resp_err) |-> (resp_data == 32'h0));
endmodule

bind icache_ctrl icache_ctrl_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .inv_valid(inv_valid),
    .resp_done(resp_done), .resp_data(resp_data), .resp_err(resp_err),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ready(mem_rd_ready)
);

// File: tb/sim_icache_ctrl.sv
`timescale 1ns/1ps
module sim_icache_ctrl;
    localparam int HIT_CYC  = 3;   // HIT_DELAY+2
    localparam int MISS_CYC = 8;   // LINE_WORDS+MISS_DELAY+2
    localparam int BYP_CYC  = 2;
    localparam int NV = 9;
    // {expect_hit, address}
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 32'h0000_1008}, {1'b1, 32'h0000_1008}, {1'b1, 32'h0000_1004},
        {1'b0, 32'h0000_2000}, {1'b1, 32'h0000_1008}, {1'b0, 32'h0000_3000},
        {1'b1, 32'h0000_100C}, {1'b0, 32'h0000_2004}, {1'b1, 32'h0000_1000}};

    logic clk = 1'b0, rst_n = 1'b0;
    logic cache_en = 1'b1, req_valid = 1'b0, inv_valid = 1'b0;
    logic [31:0] req_addr = '0, inv_addr = '0;
    logic req_ready, inv_ready, resp_done, resp_err, mem_rd_valid, mem_rd_err;
    logic [31:0] resp_data, mem_rd_addr, mem_rd_data;
    logic inj = 1'b0;
    logic [31:0] inj_addr = '0;
    int n_tests = 0, n_fail = 0;
    int r_cyc, r_beats;
    logic [31:0] r_data;
    logic r_err, r_wrap_ok, r_ready1;

    always #4 clk = ~clk;

    function automatic logic [31:0] memfn(input logic [31:0] a);
        return ~a ^ 32'h1357_9BDF;
    endfunction

    assign mem_rd_data = memfn(mem_rd_addr);
    assign mem_rd_err  = inj && mem_rd_valid && (mem_rd_addr == inj_addr);

    icache_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ready(inv_ready),
        .resp_done(resp_done), .resp_data(resp_data), .resp_err(resp_err),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(1'b1), .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One fetch; records latency, memory beats, beat order and response.
    task automatic fetch(input logic [31:0] a, input logic en);
        logic [31:0] base, exp_a;
        while (!req_ready) @(negedge clk);
        cache_en = en; req_addr = a; req_valid = 1'b1;
        r_beats = 0; r_wrap_ok = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; r_cyc = 1; r_ready1 = req_ready;
        base = a & ~32'hF;
        while (!resp_done && r_cyc < 100) begin
            if (mem_rd_valid) begin
                exp_a = base + (((a[3:2] + r_beats) % 4) * 4);
                if (mem_rd_addr != exp_a) r_wrap_ok = 1'b0;
                r_beats++;
            end
            @(negedge clk);
            r_cyc++;
        end
        r_data = resp_data; r_err = resp_err;
    endtask

    task automatic inval(input logic [31:0] a, input logic en);
        while (!inv_ready) @(negedge clk);
        cache_en = en; inv_addr = a; inv_valid = 1'b1;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic expect_hit(input logic [31:0] a, input string req);
        fetch(a, 1'b1);
        chk(r_cyc == HIT_CYC && r_beats == 0, req, "hit latency/no reads", r_cyc, HIT_CYC);
        chk(r_data == memfn(a & ~32'h3), req, "hit data", r_data, memfn(a & ~32'h3));
    endtask

    task automatic expect_miss(input logic [31:0] a, input string req);
        fetch(a, 1'b1);
        chk(r_beats == 4 && r_wrap_ok, req, "refill beats/order", r_beats, 4);
        chk(r_cyc == MISS_CYC && !r_err, req, "miss latency", r_cyc, MISS_CYC);
        chk(r_data == memfn(a & ~32'h3), req, "miss data", r_data, memfn(a & ~32'h3));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state at the ports
        chk(req_ready == 1'b1, "R11", "req_ready after reset", req_ready, 1);
        chk(resp_done == 1'b0, "R11", "resp_done after reset", resp_done, 0);
        chk(mem_rd_valid == 1'b0, "R11", "mem_rd_valid after reset", mem_rd_valid, 0);

        // Vector walk: R1 data, R2 hits, R3/R4 refills, R5 victim choice
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][32]) expect_hit(VEC[i][31:0], "R1 R2 R5");
            else            expect_miss(VEC[i][31:0], "R3 R4 R5");
            if (i == 0) begin
                chk(r_ready1 == 1'b0, "R10", "req_ready while busy", r_ready1, 0);
                chk(r_err == 1'b0, "R11", "cold line refilled", r_err, 0);
            end
        end
        @(negedge clk);
        chk(resp_done == 1'b0, "R10", "done is one cycle", resp_done, 0);

        // R6: bypass, unaligned address, no allocation
        fetch(32'h0000_2006, 1'b0);
        chk(r_cyc == BYP_CYC && r_beats == 1 && r_wrap_ok, "R6", "bypass read", r_cyc, BYP_CYC);
        chk(r_data == memfn(32'h0000_2004), "R6", "bypass data", r_data, memfn(32'h0000_2004));
        fetch(32'h0000_5000, 1'b0);
        chk(r_beats == 1, "R6", "bypass new line", r_beats, 1);
        expect_hit(32'h0000_2004, "R6");
        expect_hit(32'h0000_1008, "R6");
        expect_miss(32'h0000_5000, "R6");   // evicts 0x2000 line (age rule R5)

        // R7: invalidate with cache enabled
        inval(32'h0000_7000, 1'b1);
        expect_hit(32'h0000_1004, "R7");    // non-matching tag: untouched
        inval(32'h0000_100C, 1'b1);
        expect_hit(32'h0000_5004, "R7");    // other way untouched
        expect_miss(32'h0000_1008, "R7");

        // R8: invalidate with cache disabled wipes the set
        inval(32'h0000_7000, 1'b0);
        expect_miss(32'h0000_1008, "R8");
        expect_miss(32'h0000_5000, "R8");

        // R9: error on the first refill beat
        inj_addr = 32'h0000_4018; inj = 1'b1;
        fetch(32'h0000_4018, 1'b1);
        inj = 1'b0;
        chk(r_err == 1'b1 && r_data == 32'h0, "R9", "error response", r_data, 0);
        chk(r_cyc == 3 && r_beats == 1, "R9", "refill aborted", r_cyc, 3);
        expect_miss(32'h0000_4018, "R9");
        expect_hit(32'h0000_4010, "R9");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule